// File: doc/BRIEF.md
# Edge/Level Selectable Interrupt Request Latch

This block holds the pending-request register of one eight-line interrupt controller. Each raw request line first passes through a synchronizer. A per-line trigger-mode bit then chooses one of two behaviours. In edge mode, the line latches a request on a rising transition and keeps it until the request is accepted. In level mode, the line follows the synchronized input directly.

Software programs the trigger-mode register through a small byte-wide write port. The same port carries controller command writes, and one of those commands performs an initialization. A constant mask, fixed per instance, decides which lines may ever be placed in level mode. The primary controller of a pair uses mask 0xF8. The secondary uses 0xDE.

The logic that accepts a request reports the accepted line on the acknowledge inputs. That clears the pending bit of the named line.

Top module: `irq_trigger_latch`

## Requirements
- R1: After a synchronous reset, `pending` and `trig_mode` are all zero.
- R2: A write with `wr_sel`=1 stores `wr_data & LEVEL_MASK` into the trigger-mode register, visible on `trig_mode` one cycle later. A bit value of 1 selects level mode and 0 selects edge mode.
- R3: Lines whose mask bit is 0 always read back as edge mode. With mask 0xF8 these are lines 0 to 2. With mask 0xDE these are lines 0 and 5.
- R4: In level mode, a pending bit follows its input. A change on `req_in` appears on `pending` three clock edges later: two synchronizer stages, then the pending register.
- R5: In edge mode, a pending bit is set when the synchronized input is high and the previously seen level was low.
- R6: In edge mode, a low input never clears a pending bit.
- R7: In edge mode, a line that stays high does not set its pending bit again. The input must be seen low first.
- R8: `ack_valid` with `ack_line`=n clears pending bit n on the next edge. For a level-mode line whose input is still high, the bit returns one cycle after that.
- R9: A write with `wr_sel`=0 and `wr_data` bit 4 set is an initialization. It clears the pending bits, the remembered levels and the trigger-mode register. The mask still applies to later mode writes.
- R10: A write with `wr_sel`=0 and `wr_data` bit 4 clear changes neither `pending` nor `trig_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NLINES | Raw interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: command register, 1: trigger-mode register |
| wr_data | input | 8 | Write byte |
| ack_valid | input | 1 | Request accepted this cycle |
| ack_line | input | IDX_W | Index of the accepted line |
| pending | output | NLINES | Pending request register |
| trig_mode | output | NLINES | Trigger-mode register readback |

## Verification
Directed sequences run one edge-mode line and one level-mode line side by side. Dropping both inputs then shows level following against edge memory. Holding an edge line high across an acknowledge shows that re-arming needs a low level, while the same pattern on a level line brings the bit back. Command bytes with and without the initialization bit show that only the flagged command clears state. A seeded random phase mixes request toggles, mode writes, acknowledges and occasional initializations, and compares every cycle against a cycle model derived from the requirements.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int BYTE_W       = 8;
  localparam int CMD_INIT_BIT = 4;
  typedef enum logic {SEL_CMD = 1'b0, SEL_MODE = 1'b1} wr_target_e;
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
  parameter int               NLINES     = 8,
  parameter logic [NLINES-1:0] LEVEL_MASK = 8'hF8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              wr,
  input  logic [NLINES-1:0] data,
  output logic [NLINES-1:0] mode
);
  always_ff @(posedge clk) begin
    if (rst || init) mode <= '0;
    else if (wr)     mode <= data & LEVEL_MASK;
  end

  // R2: a mode write lands masked one edge later
  p_mode_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && !init) |=> (mode == ($past(data) & LEVEL_MASK)));

  // R3: a line outside the mask never reads as level mode
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((mode & ~LEVEL_MASK) == '0));
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic level,
  input  logic sample,
  input  logic clr,
  output logic pend
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      pend <= 1'b0;
      prev <= 1'b0;
    end else begin
      prev <= sample;
      if (level)                pend <= sample & ~clr;
      else if (sample && !prev) pend <= 1'b1;
      else if (clr)             pend <= 1'b0;
    end
  end

  // R4: level line copies the sampled input
  p_level_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (level && !init && !clr) |=> (pend == $past(sample)));

  // R5: rising sample on an edge line latches a request
  p_edge_set_r5: assert property (@(posedge clk) disable iff (rst)
    (!level && !init && sample && !prev) |=> pend);

  // R6: edge line keeps its request without acknowledge
  p_edge_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!level && !init && !clr && pend) |=> pend);

  // R8: acknowledge clears an edge line with no new rise
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!level && !init && clr && !(sample && !prev)) |=> !pend);
endmodule

// File: rtl/irq_trigger_latch.sv
module irq_trigger_latch
  import irq_trig_pkg::*;
#(
  parameter int                NLINES      = 8,
  parameter logic [NLINES-1:0] LEVEL_MASK  = 8'hF8,
  parameter int                SYNC_STAGES = 2,
  parameter int                IDX_W       = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_in,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_line,
  output logic [NLINES-1:0] pending,
  output logic [NLINES-1:0] trig_mode
);
  logic              init_cmd;
  logic              mode_wr;
  logic [NLINES-1:0] req_s;
  logic [NLINES-1:0] clr_vec;

  assign init_cmd = wr_en && (wr_target_e'(wr_sel) == SEL_CMD) && wr_data[CMD_INIT_BIT];
  assign mode_wr  = wr_en && (wr_target_e'(wr_sel) == SEL_MODE);

  irq_req_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_in),
    .q   (req_s)
  );

  irq_mode_reg #(.NLINES(NLINES), .LEVEL_MASK(LEVEL_MASK)) u_mode (
    .clk  (clk),
    .rst  (rst),
    .init (init_cmd),
    .wr   (mode_wr),
    .data (wr_data[NLINES-1:0]),
    .mode (trig_mode)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign clr_vec[i] = ack_valid && (ack_line == IDX_W'(i));
    irq_line_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .init   (init_cmd),
      .level  (trig_mode[i]),
      .sample (req_s[i]),
      .clr    (clr_vec[i]),
      .pend   (pending[i])
    );
  end

  // R9: initialization empties both registers
  p_init_clear_r9: assert property (@(posedge clk) disable iff (rst)
    init_cmd |=> ((pending == '0) && (trig_mode == '0)));

  // R10: a command byte without the init flag leaves the mode register alone
  p_cmd_noeffect_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && !wr_data[CMD_INIT_BIT]) |=> $stable(trig_mode));

  // R1: reset empties both registers
  p_reset_r1: assert property (@(posedge clk)
    rst |=> ((pending == '0) && (trig_mode == '0)));
endmodule

// File: tb/tb_irq_trigger_latch.sv
module tb_irq_trigger_latch;
  localparam int CLK_P = 10;
  localparam logic [7:0] M_MASK = 8'hF8;
  localparam logic [7:0] S_MASK = 8'hDE;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_in = '0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_line = '0;
  logic [7:0] pending, trig_mode, pending_s, trig_mode_s;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_trigger_latch #(.LEVEL_MASK(M_MASK)) dut (
    .clk(clk), .rst(rst), .req_in(req_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack_valid(ack_valid), .ack_line(ack_line),
    .pending(pending), .trig_mode(trig_mode));

  irq_trigger_latch #(.LEVEL_MASK(S_MASK)) dut_slave (
    .clk(clk), .rst(rst), .req_in(req_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack_valid(ack_valid), .ack_line(ack_line),
    .pending(pending_s), .trig_mode(trig_mode_s));

  // Cycle model of the primary instance, built from the requirements
  logic [7:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_pend = '0, m_trig = '0;

  function automatic logic [7:0] next_pend(input logic [7:0] s, prev, pend, trig, clr);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (trig[i])             r[i] = s[i] & ~clr[i];
      else if (s[i] && !prev[i]) r[i] = 1'b1;
      else if (clr[i])         r[i] = 1'b0;
      else                     r[i] = pend[i];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    logic [7:0] clr;
    logic init;
    clr  = ack_valid ? (8'h01 << ack_line) : 8'h00;
    init = wr_en && !wr_sel && wr_data[4];
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_trig = '0;
    end else begin
      if (init) begin
        m_pend = '0; m_prev = '0; m_trig = '0;
      end else begin
        m_pend = next_pend(m_s2, m_prev, m_pend, m_trig, clr);
        m_prev = m_s2;
        if (wr_en && wr_sel) m_trig = wr_data & M_MASK;
      end
      m_s2 = m_s1;
      m_s1 = req_in;
    end
  end

  task automatic check8(input string tag, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic ack(input logic [2:0] ln);
    ack_valid = 1'b1; ack_line = ln;
    cyc(1);
    ack_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check8("R1 pending after reset", pending, 8'h00);
    check8("R1 mode after reset", trig_mode, 8'h00);
    rst = 1'b0;
    cyc(1);

    write(1'b1, 8'hFF);
    check8("R2 R3 primary mask", trig_mode, 8'hF8);
    check8("R3 secondary mask", trig_mode_s, 8'hDE);
    write(1'b1, 8'h08);
    check8("R2 mode write", trig_mode, 8'h08);

    req_in = 8'h09; cyc(2);
    check8("R4 latency not before third edge", pending, 8'h00);
    cyc(1);
    check8("R4 R5 level and edge rise", pending, 8'h09);
    req_in = 8'h00; cyc(3);
    check8("R4 R6 level drops, edge held", pending, 8'h01);

    ack(3'd0);
    check8("R8 ack clears edge line", pending, 8'h00);
    req_in = 8'h01; cyc(3);
    check8("R5 new rise", pending, 8'h01);
    ack(3'd0); cyc(3);
    check8("R7 steady high no retrigger", pending, 8'h00);
    req_in = 8'h00; cyc(3); req_in = 8'h01; cyc(3);
    check8("R7 retrigger after low", pending, 8'h01);

    req_in = 8'h09; cyc(3);
    check8("R4 level line up", pending, 8'h09);
    ack(3'd3);
    check8("R8 ack clears level line", pending, 8'h01);
    cyc(1);
    check8("R8 level line returns", pending, 8'h09);

    write(1'b0, 8'hEF);
    check8("R10 mode unchanged", trig_mode, 8'h08);
    check8("R10 pending unchanged", pending, 8'h09);
    write(1'b0, 8'h10);
    check8("R9 init clears pending", pending, 8'h00);
    check8("R9 init clears mode", trig_mode, 8'h00);
    write(1'b1, 8'h07);
    check8("R9 mask kept after init", trig_mode, 8'h00);

    // Seeded random phase against the cycle model
    void'($urandom(32'h1D0C));
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 30) req_in = req_in ^ (8'h01 << $urandom_range(0, 7));
      wr_en = 1'b0; ack_valid = 1'b0;
      if (r >= 90) begin
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'($urandom);
      end else if (r == 89) begin
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'($urandom);
      end else if (r >= 75) begin
        ack_valid = 1'b1; ack_line = 3'($urandom_range(0, 7));
      end
      cyc(1);
      check8("R4 R5 R6 R8 random pending", pending, m_pend);
      check8("R2 R9 random mode", trig_mode, m_trig);
    end
    wr_en = 1'b0; ack_valid = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule